// File: doc/BRIEF.md
# Banked Address Extension Unit

This unit widens a 16-bit logical address into a 24-bit physical address. A requester presents a 16-bit offset and a 3-bit bank select. The unit looks up an 8-bit bank value and places it above the offset to form the physical address. The bank values sit in a register file that holds 256 contexts of eight entries each. An 8-bit context register chooses which set of eight entries is active. The bank select roles are fixed by convention: code 0 serves instruction fetch and page-local data, 1 indirect data, 2 the hardware stack, 3 page zero, and 4 to 7 general use.

After reset the stored bank values are not trusted. Every memory address is therefore pinned to a fixed boot bank, which is 0x80, or 0x00 when the RAM-only strap is high. The first bank-register write lifts this pin for good, until the next reset. Interrupt acceptance forces the context to 0, and a trap forces it to 1. I/O transactions drive the upper eight address bits to zero.

Top module: `bank_addr_ext`

## Requirements
- R1: When not masked and not an I/O access, `paddr_o[23:16]` equals the bank entry `[ctx_o][sel_i]` and `paddr_o[15:0]` equals `ofs_i`. Both follow the inputs in the same cycle.
- R2: Offsets never carry into the bank field. With bank value b, offset 0xFFFF gives b:FFFF and offset 0x0000 gives b:0000.
- R3: A bank write with `bk_we_i`=1 stores `bk_wdata_i` into entry `[ctx_o][bk_idx_i]` at the next rising edge. `bk_rdata_o` shows entry `[ctx_o][bk_idx_i]` combinationally. Entries of other contexts and other indexes are not touched.
- R4: From reset until the first bank write, every non-I/O address has upper byte 0x80, or 0x00 when `ram_only_i`=1, whatever `sel_i` and `ctx_o` are.
- R5: The first bank write releases the mask from the following edge on. The stored entries are then used and the mask stays released until reset.
- R6: `irq_ack_i`=1 sets `ctx_o` to 0 at the next edge. It has priority over `trap_i` and `ctx_we_i`.
- R7: `trap_i`=1 without `irq_ack_i` sets `ctx_o` to 1 at the next edge. It has priority over `ctx_we_i`.
- R8: `ctx_we_i`=1 alone loads `ctx_wdata_i` into the context at the next edge. Without any of the three requests the context holds its value. Reset sets it to 0.
- R9: With `io_i`=1, `paddr_o[23:16]` is 0x00 both while masked and after the mask is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| ram_only_i | input | 1 | Strap selecting boot bank 0x00 instead of 0x80 |
| ofs_i | input | 16 | Logical offset |
| sel_i | input | 3 | Bank select for the address lookup |
| io_i | input | 1 | Current transaction is in I/O space |
| paddr_o | output | 24 | Physical address for the address register |
| bk_we_i | input | 1 | Bank register write strobe |
| bk_idx_i | input | 3 | Bank register index for write and read |
| bk_wdata_i | input | 8 | Bank register write value |
| bk_rdata_o | output | 8 | Bank register read value of the active context |
| ctx_we_i | input | 1 | Context register write strobe |
| ctx_wdata_i | input | 8 | Context register write value |
| ctx_o | output | 8 | Current context |
| irq_ack_i | input | 1 | Interrupt accepted, forces context 0 |
| trap_i | input | 1 | Trap executed, forces context 1 |

## Verification
On every cycle the assertions check these rules: the offset passes straight through, the I/O upper byte is zero, the masked address uses the boot bank, the mask drops after a write and never comes back, and the context obeys interrupt, trap, write and hold rules with their priority. Only the bench scenarios show that a write lands in the right context and index. They also show that other contexts keep their contents across switches and that a second reset masks the stored values again. The bench's per-cycle reference model covers the lookup value itself.

// File: rtl/bae_pkg.sv
package bae_pkg;

  typedef enum logic [1:0] {
    CTX_KEEP = 2'd0,
    CTX_LOAD = 2'd1,
    CTX_TRAP = 2'd2,
    CTX_IRQ  = 2'd3
  } ctx_src_e;

  // Interrupt over trap over software write.
  function automatic ctx_src_e ctx_pick(input logic irq, input logic trap, input logic we);
    ctx_src_e src;
    if (irq)       src = CTX_IRQ;
    else if (trap) src = CTX_TRAP;
    else if (we)   src = CTX_LOAD;
    else           src = CTX_KEEP;
    return src;
  endfunction

endpackage

// File: rtl/bae_ctx_reg.sv
module bae_ctx_reg #(
  parameter int          CTX_W    = 8,
  parameter logic [7:0]  IRQ_CTX  = 8'd0,
  parameter logic [7:0]  TRAP_CTX = 8'd1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             irq_i,
  input  logic             trap_i,
  input  logic             we_i,
  input  logic [CTX_W-1:0] wdata_i,
  output logic [CTX_W-1:0] ctx_o
);
  import bae_pkg::*;

  logic [CTX_W-1:0] ctx_q;
  logic [CTX_W-1:0] ctx_d;
  logic             ctx_en;
  ctx_src_e         src;

  always_comb begin
    src    = ctx_pick(irq_i, trap_i, we_i);
    ctx_en = (src != CTX_KEEP);
    unique case (src)
      CTX_IRQ:  ctx_d = CTX_W'(IRQ_CTX);
      CTX_TRAP: ctx_d = CTX_W'(TRAP_CTX);
      CTX_LOAD: ctx_d = wdata_i;
      default:  ctx_d = ctx_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ctx_q <= '0;
    else if (ctx_en) ctx_q <= ctx_d;
  end

  assign ctx_o = ctx_q;

endmodule

// File: rtl/bae_mask_ctl.sv
module bae_mask_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic release_i,
  output logic masked_o
);
  logic mask_q;
  logic mask_d;
  logic mask_en;

  always_comb begin
    mask_en = mask_q & release_i;
    mask_d  = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mask_q <= 1'b1;
    else if (mask_en) mask_q <= mask_d;
  end

  assign masked_o = mask_q;

endmodule

// File: rtl/bae_bank_file.sv
module bae_bank_file #(
  parameter int DW  = 8,
  parameter int AW  = 11,
  parameter int NRD = 2
) (
  input  logic                    clk,
  input  logic                    we_i,
  input  logic [AW-1:0]           waddr_i,
  input  logic [DW-1:0]           wdata_i,
  input  logic [NRD-1:0][AW-1:0]  raddr_i,
  output logic [NRD-1:0][DW-1:0]  rdata_o
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  // Storage only: no reset, contents are undefined until written.
  always_ff @(posedge clk) begin
    if (we_i) mem[waddr_i] <= wdata_i;
  end

  for (genvar p = 0; p < NRD; p++) begin : g_rd
    assign rdata_o[p] = mem[raddr_i[p]];
  end

endmodule

// File: rtl/bank_addr_ext.sv
module bank_addr_ext #(
  parameter int         OFS_W     = 16,
  parameter int         BANK_W    = 8,
  parameter int         SEL_W     = 3,
  parameter int         CTX_W     = 8,
  parameter logic [7:0] ROM_BANK  = 8'h80,
  parameter logic [7:0] RAM_BANK  = 8'h00,
  parameter logic [7:0] IRQ_CTX   = 8'd0,
  parameter logic [7:0] TRAP_CTX  = 8'd1,
  localparam int        PA_W      = BANK_W + OFS_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ram_only_i,
  input  logic [OFS_W-1:0]  ofs_i,
  input  logic [SEL_W-1:0]  sel_i,
  input  logic              io_i,
  output logic [PA_W-1:0]   paddr_o,
  input  logic              bk_we_i,
  input  logic [SEL_W-1:0]  bk_idx_i,
  input  logic [BANK_W-1:0] bk_wdata_i,
  output logic [BANK_W-1:0] bk_rdata_o,
  input  logic              ctx_we_i,
  input  logic [CTX_W-1:0]  ctx_wdata_i,
  output logic [CTX_W-1:0]  ctx_o,
  input  logic              irq_ack_i,
  input  logic              trap_i
);
  localparam int AW       = CTX_W + SEL_W;
  localparam int NRD      = 2;
  localparam int RD_XLATE = 0;
  localparam int RD_SW    = 1;

  logic [CTX_W-1:0]            ctx_q;
  logic                        mask_q;
  logic [NRD-1:0][AW-1:0]      rd_addr;
  logic [NRD-1:0][BANK_W-1:0]  rd_data;
  logic [AW-1:0]               wr_addr;
  logic [BANK_W-1:0]           bank_sel;

  bae_ctx_reg #(
    .CTX_W    (CTX_W),
    .IRQ_CTX  (IRQ_CTX),
    .TRAP_CTX (TRAP_CTX)
  ) u_ctx (
    .clk     (clk),
    .rst_n   (rst_n),
    .irq_i   (irq_ack_i),
    .trap_i  (trap_i),
    .we_i    (ctx_we_i),
    .wdata_i (ctx_wdata_i),
    .ctx_o   (ctx_q)
  );

  bae_mask_ctl u_mask (
    .clk       (clk),
    .rst_n     (rst_n),
    .release_i (bk_we_i),
    .masked_o  (mask_q)
  );

  assign wr_addr           = {ctx_q, bk_idx_i};
  assign rd_addr[RD_XLATE] = {ctx_q, sel_i};
  assign rd_addr[RD_SW]    = {ctx_q, bk_idx_i};

  bae_bank_file #(
    .DW  (BANK_W),
    .AW  (AW),
    .NRD (NRD)
  ) u_file (
    .clk     (clk),
    .we_i    (bk_we_i),
    .waddr_i (wr_addr),
    .wdata_i (bk_wdata_i),
    .raddr_i (rd_addr),
    .rdata_o (rd_data)
  );

  always_comb begin
    if (io_i)        bank_sel = '0;
    else if (mask_q) bank_sel = ram_only_i ? BANK_W'(RAM_BANK) : BANK_W'(ROM_BANK);
    else             bank_sel = rd_data[RD_XLATE];
  end

  assign paddr_o    = {bank_sel, ofs_i};
  assign bk_rdata_o = rd_data[RD_SW];
  assign ctx_o      = ctx_q;

endmodule

// File: rtl/bank_addr_ext_chk.sv
module bank_addr_ext_chk #(
  parameter int OFS_W  = 16,
  parameter int BANK_W = 8,
  parameter int CTX_W  = 8
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      ram_only_i,
  input logic [OFS_W-1:0]          ofs_i,
  input logic                      io_i,
  input logic [BANK_W+OFS_W-1:0]   paddr_o,
  input logic                      bk_we_i,
  input logic                      ctx_we_i,
  input logic [CTX_W-1:0]          ctx_wdata_i,
  input logic [CTX_W-1:0]          ctx_o,
  input logic                      irq_ack_i,
  input logic                      trap_i,
  input logic                      mask_q
);
  AST_OFS_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    paddr_o[OFS_W-1:0] == ofs_i); // R2
  AST_IO_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    io_i |-> paddr_o[BANK_W+OFS_W-1:OFS_W] == '0); // R9
  AST_MASK_BOOT_BANK: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q && !io_i) |-> paddr_o[BANK_W+OFS_W-1:OFS_W] == (ram_only_i ? 8'h00 : 8'h80)); // R4
  AST_MASK_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    bk_we_i |=> !mask_q); // R5
  AST_MASK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !mask_q |=> !mask_q); // R5
  AST_IRQ_CTX: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ack_i |=> ctx_o == '0); // R6
  AST_TRAP_CTX: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_i && !irq_ack_i) |=> ctx_o == CTX_W'(1)); // R7
  AST_CTX_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (ctx_we_i && !trap_i && !irq_ack_i) |=> ctx_o == $past(ctx_wdata_i)); // R8
  AST_CTX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctx_we_i && !trap_i && !irq_ack_i) |=> $stable(ctx_o)); // R8
endmodule

bind bank_addr_ext bank_addr_ext_chk #(
  .OFS_W  (OFS_W),
  .BANK_W (BANK_W),
  .CTX_W  (CTX_W)
) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .ram_only_i  (ram_only_i),
  .ofs_i       (ofs_i),
  .io_i        (io_i),
  .paddr_o     (paddr_o),
  .bk_we_i     (bk_we_i),
  .ctx_we_i    (ctx_we_i),
  .ctx_wdata_i (ctx_wdata_i),
  .ctx_o       (ctx_o),
  .irq_ack_i   (irq_ack_i),
  .trap_i      (trap_i),
  .mask_q      (mask_q)
);

// File: tb/bank_addr_ext_tb_top.sv
`timescale 1ns/1ps
module bank_addr_ext_tb_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        ram_only;
  logic [15:0] ofs;
  logic [2:0]  sel;
  logic        io;
  logic [23:0] paddr;
  logic        bk_we;
  logic [2:0]  bk_idx;
  logic [7:0]  bk_wdata;
  logic [7:0]  bk_rdata;
  logic        ctx_we;
  logic [7:0]  ctx_wdata;
  logic [7:0]  ctx;
  logic        irq;
  logic        trap;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  bank_addr_ext dut_i (
    .clk(clk), .rst_n(rst_n), .ram_only_i(ram_only), .ofs_i(ofs), .sel_i(sel),
    .io_i(io), .paddr_o(paddr), .bk_we_i(bk_we), .bk_idx_i(bk_idx),
    .bk_wdata_i(bk_wdata), .bk_rdata_o(bk_rdata), .ctx_we_i(ctx_we),
    .ctx_wdata_i(ctx_wdata), .ctx_o(ctx), .irq_ack_i(irq), .trap_i(trap)
  );

  // Behavioural reference model
  logic [7:0] ref_bank [int];
  int         ref_ctx;
  bit         ref_mask;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_mask = 1'b1;
      ref_ctx  = 0;
    end else begin
      if (bk_we) begin
        ref_bank[ref_ctx * 8 + int'(bk_idx)] = bk_wdata;
        ref_mask = 1'b0;
      end
      if (irq)         ref_ctx = 0;
      else if (trap)   ref_ctx = 1;
      else if (ctx_we) ref_ctx = int'(ctx_wdata);
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // Per-cycle comparison against the model
  always @(negedge clk) begin
    #2;
    if (rst_n && !done) begin
      int key;
      key = ref_ctx * 8 + int'(sel);
      check("R8 ctx model", 32'(ctx), 32'(ref_ctx));
      if (io)
        check("R9 model io", 32'(paddr), {8'h00, 8'h00, ofs});
      else if (ref_mask)
        check("R4 model mask", 32'(paddr), {8'h00, (ram_only ? 8'h00 : 8'h80), ofs});
      else if (ref_bank.exists(key))
        check("R1 model lookup", 32'(paddr), {8'h00, ref_bank[key], ofs});
      key = ref_ctx * 8 + int'(bk_idx);
      if (ref_bank.exists(key))
        check("R3 model read", 32'(bk_rdata), 32'(ref_bank[key]));
    end
  end

  task automatic tick();
    @(negedge clk);
    bk_we = 1'b0; ctx_we = 1'b0; irq = 1'b0; trap = 1'b0;
  endtask

  task automatic settle();
    #1;
  endtask

  initial begin
    int wd;
    wd = 0;
    while (!done && wd < 100000) begin
      @(posedge clk);
      wd++;
    end
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; ram_only = 1'b0; ofs = 16'h0; sel = 3'd0; io = 1'b0;
    bk_we = 1'b0; bk_idx = 3'd0; bk_wdata = 8'h0; ctx_we = 1'b0;
    ctx_wdata = 8'h0; irq = 1'b0; trap = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // Reset state: masked to ROM bank, context 0
    tick(); sel = 3'd3; ofs = 16'h1234; settle();
    check("R4 boot rom bank", 32'(paddr), 32'h801234);
    check("R8 reset ctx", 32'(ctx), 32'h0);
    tick(); sel = 3'd7; ram_only = 1'b1; settle();
    check("R4 ram-only bank", 32'(paddr), 32'h001234);
    tick(); ram_only = 1'b0; io = 1'b1; ofs = 16'h0042; settle();
    check("R9 io while masked", 32'(paddr), 32'h000042);
    io = 1'b0;

    // Context write does not lift the mask
    tick(); ctx_we = 1'b1; ctx_wdata = 8'd5;
    tick(); settle();
    check("R8 ctx load", 32'(ctx), 32'd5);
    check("R4 still masked", 32'(paddr[23:16]), 32'h80);

    // First write releases the mask
    tick(); bk_we = 1'b1; bk_idx = 3'd0; bk_wdata = 8'h10; sel = 3'd0; settle();
    check("R4 masked in write cycle", 32'(paddr[23:16]), 32'h80);
    tick(); bk_idx = 3'd0; settle();
    check("R5 mask released", 32'(paddr[23:16]), 32'h10);
    check("R3 read back", 32'(bk_rdata), 32'h10);
    for (int i = 1; i < 8; i++) begin
      tick(); bk_we = 1'b1; bk_idx = 3'(i); bk_wdata = 8'(8'h10 + i);
    end
    tick(); sel = 3'd4; bk_idx = 3'd6; settle();
    check("R1 lookup sel4", 32'(paddr[23:16]), 32'h14);
    check("R3 read idx6", 32'(bk_rdata), 32'h16);

    // Second context, then return: first context untouched
    tick(); ctx_we = 1'b1; ctx_wdata = 8'd6;
    for (int i = 0; i < 8; i++) begin
      tick(); bk_we = 1'b1; bk_idx = 3'(i); bk_wdata = 8'(8'h60 + i);
    end
    tick(); sel = 3'd2; settle();
    check("R1 ctx6 lookup", 32'(paddr[23:16]), 32'h62);
    tick(); ctx_we = 1'b1; ctx_wdata = 8'd5;
    tick(); bk_idx = 3'd2; settle();
    check("R3 ctx5 kept", 32'(bk_rdata), 32'h12);

    // Offset wrap inside bank
    tick(); sel = 3'd1; ofs = 16'hFFFF; settle();
    check("R2 top of bank", 32'(paddr), 32'h11FFFF);
    tick(); ofs = 16'h0000; settle();
    check("R2 wrap to zero", 32'(paddr), 32'h110000);
    tick(); io = 1'b1; settle();
    check("R9 io after release", 32'(paddr[23:16]), 32'h00);
    io = 1'b0;

    // Mask stays released even with strap changes
    tick(); ram_only = 1'b1; sel = 3'd4; settle();
    check("R5 sticky release", 32'(paddr[23:16]), 32'h14);
    ram_only = 1'b0;

    // Forced contexts and priority
    tick(); irq = 1'b1; ctx_we = 1'b1; ctx_wdata = 8'd6;
    tick(); settle();
    check("R6 irq over write", 32'(ctx), 32'd0);
    tick(); trap = 1'b1; ctx_we = 1'b1; ctx_wdata = 8'd6;
    tick(); settle();
    check("R7 trap over write", 32'(ctx), 32'd1);
    tick(); irq = 1'b1; trap = 1'b1;
    tick(); settle();
    check("R6 irq over trap", 32'(ctx), 32'd0);
    tick(); tick(); settle();
    check("R8 hold", 32'(ctx), 32'd0);

    // Second reset masks again
    tick(); rst_n = 1'b0;
    tick(); rst_n = 1'b1; sel = 3'd4; settle();
    check("R4 remask after reset", 32'(paddr[23:16]), 32'h80);
    tick();

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule